// File: doc/BRIEF.md
# Power-Management Configuration with Periodic Interrupt

This block holds one 16-bit power-management control word behind a plain write-enable / read-data port. The word carries a two-bit period select for a periodic system-management interrupt, a global enable for that interrupt, a sticky lock that freezes the enable, and an enable for the processor sleep output. It also shows the synchronized level of the power-button pin.

A period counter advances on every one-second tick pulse and raises a one-cycle interrupt pulse at the end of each selected period. The interrupt only reaches the output while the global enable is set. The active-low processor sleep output follows a 3-bit sleep-state code. The enable bit governs the light sleep state. The deep states always force the output active.

Top module: `pm_config_ctrl`

## Requirements
- R1: Field `rate` (bits 1:0) selects the interrupt period in ticks: 0 gives 64, 1 gives 32, 2 gives 16, 3 gives 8. With the enable set, `smi_pulse` is high for exactly one cycle, in the cycle after the clock edge that samples the period's last tick.
- R2: A write that changes `rate` clears the period counter. The first pulse then follows one full new period of ticks after the write.
- R3: Bit 2 (`smi_en`) gates the pulse and has no effect on the counter, which keeps running while `smi_en` is 0.
- R4: Bit 3 (`lock`) is set by writing 1. Writing 0 leaves it set, and only `rst_n` clears it. While `lock` is 1, writes leave `smi_en` unchanged.
- R5: For sleep code 1, `cpu_sleep_n` is 0 when bit 4 (`slp_en`) is 1 and 1 when it is 0. For codes 0, 2, 6 and 7 it is 1. The output is registered, so it changes one cycle after the code does.
- R6: For sleep codes 3, 4 and 5, `cpu_sleep_n` is 0 whatever `slp_en` holds.
- R7: Bit 5 shows the level of `pwrbtn_in` two clock edges after the pin changes. Writes to bit 5 have no effect.
- R8: After reset every field reads 0, `smi_pulse` is 0 and `cpu_sleep_n` is 1. Bits 15:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low platform reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word |
| pwrbtn_in | input | 1 | Asynchronous power-button level |
| sec_tick | input | 1 | One-cycle pulse once per second |
| sleep_state | input | 3 | Sleep-state code (0 S0, 1 S1, 3 S3, 4 S4, 5 S5) |
| smi_pulse | output | 1 | Periodic interrupt pulse |
| cpu_sleep_n | output | 1 | Active-low processor sleep output |

## Verification
A counter in the wrong state shows at `smi_pulse` as a pulse that lands on the wrong tick, or as two pulses close together. This shows up within one period, at most 64 ticks. A lock or enable bit in the wrong state appears on the next read of `rd_data`, or as pulses that are missing or extra at the next period boundary. A mistake in the sleep decode appears on `cpu_sleep_n` one cycle after the code is applied. The bench therefore sweeps every rate over two periods and every sleep code against both enable values.

// File: rtl/pm_config_pkg.sv
package pm_config_pkg;
  localparam int REG_W      = 16;
  localparam int RATE_W     = 2;
  localparam int STATE_W    = 3;
  localparam int F_RATE_LO  = 0;
  localparam int F_SMI_EN   = 2;
  localparam int F_LOCK     = 3;
  localparam int F_SLP_EN   = 4;
  localparam int F_PWRBTN   = 5;

  localparam logic [STATE_W-1:0] ST_S1 = 3'd1;
  localparam logic [STATE_W-1:0] ST_S3 = 3'd3;
  localparam logic [STATE_W-1:0] ST_S4 = 3'd4;
  localparam logic [STATE_W-1:0] ST_S5 = 3'd5;

  // Period in ticks: the longest period halves for each step of the select.
  function automatic int unsigned period_ticks(input int unsigned longest,
                                               input logic [RATE_W-1:0] rate);
    return longest >> rate;
  endfunction

  function automatic logic deep_state(input logic [STATE_W-1:0] st);
    return (st == ST_S3) || (st == ST_S4) || (st == ST_S5);
  endfunction
endpackage

// File: rtl/pm_config_regs.sv
module pm_config_regs
  import pm_config_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              pwrbtn_in,
  output logic [RATE_W-1:0] rate,
  output logic              smi_en,
  output logic              slp_en,
  output logic              rate_restart,
  output logic [REG_W-1:0]  rd_data
);
  logic lock_q;
  logic btn_s1, btn_s2;

  assign rate_restart = wr_en && (wr_data[F_RATE_LO +: RATE_W] != rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate   <= '0;
      smi_en <= 1'b0;
      lock_q <= 1'b0;
      slp_en <= 1'b0;
      btn_s1 <= 1'b0;
      btn_s2 <= 1'b0;
    end else begin
      btn_s1 <= pwrbtn_in;
      btn_s2 <= btn_s1;
      if (wr_en) begin
        rate   <= wr_data[F_RATE_LO +: RATE_W];
        slp_en <= wr_data[F_SLP_EN];
        if (!lock_q) smi_en <= wr_data[F_SMI_EN];
        if (wr_data[F_LOCK]) lock_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[F_RATE_LO +: RATE_W] = rate;
    rd_data[F_SMI_EN] = smi_en;
    rd_data[F_LOCK]   = lock_q;
    rd_data[F_SLP_EN] = slp_en;
    rd_data[F_PWRBTN] = btn_s2;
  end

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_en_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(smi_en));
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:F_PWRBTN+1] == '0);
endmodule

// File: rtl/pm_config_periodic.sv
module pm_config_periodic
  import pm_config_pkg::*;
#(
  parameter int unsigned LONGEST_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [RATE_W-1:0] rate,
  input  logic              restart,
  input  logic              smi_en,
  output logic              smi_pulse
);
  localparam int CNT_W = $clog2(LONGEST_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             period_end;

  assign last_cnt   = CNT_W'(period_ticks(LONGEST_TICKS, rate) - 1);
  assign period_end = sec_tick && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      smi_pulse <= 1'b0;
    end else begin
      smi_pulse <= period_end && smi_en && !restart;
      if (restart)         cnt_q <= '0;
      else if (period_end) cnt_q <= '0;
      else if (sec_tick)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt || $past(restart));
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !smi_pulse);
  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_en |=> !smi_pulse);
endmodule

// File: rtl/pm_config_sleep.sv
module pm_config_sleep
  import pm_config_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] sleep_state,
  input  logic               slp_en,
  output logic               cpu_sleep_n
);
  logic want_sleep;

  assign want_sleep = deep_state(sleep_state) || (slp_en && sleep_state == ST_S1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_sleep_n <= 1'b1;
    else        cpu_sleep_n <= !want_sleep;
  end

  assert_deep_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deep_state(sleep_state) |=> !cpu_sleep_n);
  assert_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == '0) |=> cpu_sleep_n);
endmodule

// File: rtl/pm_config_ctrl.sv
module pm_config_ctrl
  import pm_config_pkg::*;
#(
  parameter int unsigned LONGEST_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        pwrbtn_in,
  input  logic        sec_tick,
  input  logic [2:0]  sleep_state,
  output logic        smi_pulse,
  output logic        cpu_sleep_n
);
  logic [RATE_W-1:0] rate;
  logic              smi_en, slp_en, rate_restart;

  pm_config_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pwrbtn_in(pwrbtn_in), .rate(rate), .smi_en(smi_en), .slp_en(slp_en),
    .rate_restart(rate_restart), .rd_data(rd_data)
  );

  pm_config_periodic #(.LONGEST_TICKS(LONGEST_TICKS)) u_periodic (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rate(rate),
    .restart(rate_restart), .smi_en(smi_en), .smi_pulse(smi_pulse)
  );

  pm_config_sleep u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_state(sleep_state), .slp_en(slp_en),
    .cpu_sleep_n(cpu_sleep_n)
  );
endmodule

// File: tb/tb_pm_config_ctrl.sv
module tb_pm_config_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pwrbtn_in = 1'b0;
  logic        sec_tick = 1'b0;
  logic [2:0]  sleep_state = '0;
  logic        smi_pulse, cpu_sleep_n;
  int total = 0, bad = 0, cycles = 0;

  pm_config_ctrl dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // One tick; returns whether the pulse appeared in the following cycle.
  task automatic tick(output bit hit);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; hit = smi_pulse;
  endtask

  task automatic ticks_to_pulse(input int limit, output int n);
    bit h;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      tick(h);
      if (h) begin n = i; return; end
    end
  endtask

  initial begin
    bit h;
    int n, cnt, first, exp_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset word", rd_data, 0);
    check("R8 reset pulse", smi_pulse, 0);
    check("R8 reset sleep out", cpu_sleep_n, 1);

    // R8 reserved bits: write all ones, only defined fields may read back
    wr(16'hFFF7);                       // lock clear so test stays reusable
    check("R8 reserved zero", rd_data, 16'h0017);
    wr(16'h0000);

    // R1 sweep all rates over two periods
    for (int r = 0; r < 4; r++) begin
      exp_n = 64 >> r;
      wr(16'(r | 4));
      check("R1 rate readback", rd_data[1:0], r);
      cnt = 0; first = 0;
      for (int i = 1; i <= 2 * exp_n; i++) begin
        tick(h);
        if (h) begin cnt++; if (first == 0) first = i; end
      end
      check("R1 pulse count", cnt, 2);
      check("R1 first pulse tick", first, exp_n);
    end

    // R2 rate change restarts the counter (rate now 3)
    for (int i = 0; i < 3; i++) tick(h);
    wr(16'h0006);                       // rate 2, enabled
    ticks_to_pulse(40, n);
    check("R2 full new period", n, 16);

    // R3 gate off: counter keeps running
    wr(16'h0003);                       // rate 3, disabled, restart
    cnt = 0;
    for (int i = 0; i < 12; i++) begin tick(h); if (h) cnt++; end
    check("R3 no pulse when disabled", cnt, 0);
    wr(16'h0007);                       // same rate, enabled: no restart
    ticks_to_pulse(20, n);
    check("R3 counter kept running", n, 4);

    // R5/R6 sleep code sweep
    for (int e = 0; e < 2; e++) begin
      wr(16'(e << 4));
      for (int s = 0; s < 8; s++) begin
        @(negedge clk); sleep_state = 3'(s);
        @(negedge clk);
        if (s >= 3 && s <= 5) check("R6 deep state forces sleep", cpu_sleep_n, 0);
        else check("R5 sleep output", cpu_sleep_n, (s == 1 && e == 1) ? 0 : 1);
      end
    end
    @(negedge clk); sleep_state = '0;

    // R7 power button synchronizer and read-only bit
    @(negedge clk); pwrbtn_in = 1'b1;
    @(negedge clk);
    check("R7 one edge not yet visible", rd_data[5], 0);
    @(negedge clk);
    check("R7 visible after two edges", rd_data[5], 1);
    wr(16'h0000);
    check("R7 write ignored high", rd_data[5], 1);
    @(negedge clk); pwrbtn_in = 1'b0;
    repeat (2) @(negedge clk);
    wr(16'h0020);
    check("R7 write ignored low", rd_data[5], 0);

    // R4 lock
    wr(16'h000C);                       // enable + lock
    check("R4 lock set", rd_data[3:2], 3);
    wr(16'h0000);
    check("R4 enable held", rd_data[2], 1);
    check("R4 lock sticky", rd_data[3], 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset clears lock", rd_data, 0);
    wr(16'h0004);
    check("R4 enable writable after reset", rd_data[2], 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule